// File: doc/BRIEF.md
# Serial-Programmed Four-Channel Converter Code Register

This block is the digital front end of a four-channel converter with 6-bit codes per channel. A three-wire serial port drives it: a data line, a shift clock and an active-low enable. While the enable is low, each falling edge of the shift clock moves one data bit into a 24-bit shift register, most significant bit first. When the enable returns high, the whole register is copied into four 6-bit output registers at once. These registers drive the converter code outputs.

The far end of the shift register appears on a serial output, so several of these blocks can be chained by wiring one block's serial output to the next block's data input. The serial pins are asynchronous to the system clock. Each pin passes through a two-flop synchronizer, and both edge events are detected in the system clock domain. Short frames update only the channels nearest the input. Long frames let their leading extra bits fall off the far end.

Top module: `quad_dac_loader`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `dac_codes` is all zeros, `ser_dout` is 0 and `load_done` is 0.
- R2: A falling edge of `ser_clk` while `ser_en_n` is low shifts the register left by one bit and takes `ser_din` into bit 0. The first bit sent therefore ends up as the most significant bit of its word.
- R3: The last six bits shifted in form channel 1 on `dac_codes[5:0]`. The six bits before them form channel 2 on `dac_codes[11:6]`, then channel 3 on `dac_codes[17:12]`, then channel 4 on `dac_codes[23:18]`.
- R4: Falling edges of `ser_clk` while `ser_en_n` is high leave the shift register and `ser_dout` unchanged.
- R5: On a rising edge of `ser_en_n`, all four channels take the shift register contents in the same cycle. `dac_codes` changes at no other time.
- R6: `load_done` is high for exactly one system clock, in the same cycle that `dac_codes` takes new contents.
- R7: A frame of 6, 12 or 18 bits updates channels 1, 1–2 or 1–3. The higher channels then hold the bits that were already in the register, moved up by the frame length.
- R8: A frame longer than needed is accepted. Its leading extra bits only move out of the far end. For example, an 8-bit frame sets channel 1 from its last 6 bits.
- R9: `ser_dout` always equals bit 23 of the shift register. This is the bit that the next shift pushes out.
- R10: A serial clock fall or an enable rise is acted on at the third system clock edge after the pin changes. Nothing shows at the outputs after two edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous; data moves on its falling edge |
| ser_en_n | input | 1 | Active-low serial enable, asynchronous; its rising edge loads the outputs |
| ser_din | input | 1 | Serial data in, asynchronous |
| ser_dout | output | 1 | Cascade output, far end of the shift register |
| dac_codes | output | 24 | Four 6-bit channel codes, channel 1 in the low bits |
| load_done | output | 1 | One-cycle pulse when the channel codes update |

## Verification
Two synchronizer stages and one edge register come before any action. So a shift shows on `ser_dout`, and a load shows on `dac_codes` and `load_done`, at the third rising clock edge after the pin changes. The bench changes pins on falling clock edges and samples on falling edges as well. After two edges it confirms that the old value still holds. After the third edge it checks the new value, and after the fourth edge it confirms that `load_done` has dropped. Each serial phase lasts four clocks, so every event has settled before the next pin change.

// File: rtl/dac_loader_pkg.sv
package dac_loader_pkg;
  parameter int unsigned DEF_CH_COUNT = 4;
  parameter int unsigned DEF_CODE_W   = 6;
  parameter int unsigned DEF_SYNC     = 2;

  typedef struct packed {
    logic shift;
    logic load;
    logic din;
  } ser_evt_t;
endpackage

// File: rtl/ser_port_sync.sv
module ser_port_sync #(
  parameter int unsigned STAGES = dac_loader_pkg::DEF_SYNC
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_raw,
  input  logic en_n_raw,
  input  logic din_raw,
  output dac_loader_pkg::ser_evt_t evt
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] ck_q, en_q, d_q;
  logic ck_prev, en_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_q    <= '1;
      en_q    <= '1;
      d_q     <= '0;
      ck_prev <= 1'b1;
      en_prev <= 1'b1;
    end else begin
      ck_q    <= {ck_q[LAST-1:0], sclk_raw};
      en_q    <= {en_q[LAST-1:0], en_n_raw};
      d_q     <= {d_q[LAST-1:0], din_raw};
      ck_prev <= ck_q[LAST];
      en_prev <= en_q[LAST];
    end
  end

  always_comb begin
    evt.shift = ck_prev & ~ck_q[LAST] & ~en_q[LAST];
    evt.load  = ~en_prev & en_q[LAST];
    evt.din   = d_q[LAST];
  end
endmodule

// File: rtl/ser_shift_chain.sv
module ser_shift_chain #(
  parameter int unsigned WIDTH = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             bit_in,
  output logic [WIDTH-1:0] word,
  output logic             far_bit
);
  always_ff @(posedge clk) begin
    if (rst)           word <= '0;
    else if (shift_en) word <= {word[WIDTH-2:0], bit_in};
  end

  assign far_bit = word[WIDTH-1];
endmodule

// File: rtl/code_latch_bank.sv
module code_latch_bank #(
  parameter int unsigned CH_COUNT = dac_loader_pkg::DEF_CH_COUNT,
  parameter int unsigned CODE_W   = dac_loader_pkg::DEF_CODE_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       load,
  input  logic [CH_COUNT*CODE_W-1:0] src,
  output logic [CH_COUNT*CODE_W-1:0] codes,
  output logic                       done
);
  for (genvar c = 0; c < CH_COUNT; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst)       codes[c*CODE_W +: CODE_W] <= '0;
      else if (load) codes[c*CODE_W +: CODE_W] <= src[c*CODE_W +: CODE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) done <= 1'b0;
    else     done <= load;
  end
endmodule

// File: rtl/quad_dac_loader.sv
module quad_dac_loader #(
  parameter int unsigned CH_COUNT = dac_loader_pkg::DEF_CH_COUNT,
  parameter int unsigned CODE_W   = dac_loader_pkg::DEF_CODE_W,
  parameter int unsigned STAGES   = dac_loader_pkg::DEF_SYNC
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ser_clk,
  input  logic                       ser_en_n,
  input  logic                       ser_din,
  output logic                       ser_dout,
  output logic [CH_COUNT*CODE_W-1:0] dac_codes,
  output logic                       load_done
);
  localparam int unsigned SR_W = CH_COUNT * CODE_W;

  dac_loader_pkg::ser_evt_t evt;
  logic [SR_W-1:0] sr_word;

  ser_port_sync #(.STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .sclk_raw(ser_clk), .en_n_raw(ser_en_n), .din_raw(ser_din),
    .evt(evt)
  );

  ser_shift_chain #(.WIDTH(SR_W)) u_chain (
    .clk(clk), .rst(rst),
    .shift_en(evt.shift), .bit_in(evt.din),
    .word(sr_word), .far_bit(ser_dout)
  );

  code_latch_bank #(.CH_COUNT(CH_COUNT), .CODE_W(CODE_W)) u_bank (
    .clk(clk), .rst(rst),
    .load(evt.load), .src(sr_word),
    .codes(dac_codes), .done(load_done)
  );
endmodule

// File: rtl/dac_loader_checks.sv
module dac_loader_checks #(
  parameter int unsigned SR_W = 24
) (
  input logic            clk,
  input logic            rst,
  input logic            shift_ev,
  input logic            load_ev,
  input logic [SR_W-1:0] sr_word,
  input logic            ser_dout,
  input logic [SR_W-1:0] dac_codes,
  input logic            load_done
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (dac_codes == '0 && !load_done && !ser_dout));

  assert_shift_moves_R2: assert property (@(posedge clk) disable iff (rst)
    shift_ev |=> sr_word[SR_W-1:1] == $past(sr_word[SR_W-2:0]));

  assert_hold_idle_R4: assert property (@(posedge clk) disable iff (rst)
    !shift_ev |=> $stable(sr_word) && $stable(ser_dout));

  assert_parallel_load_R5: assert property (@(posedge clk) disable iff (rst)
    load_ev |=> dac_codes == $past(sr_word));

  assert_codes_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !load_done |-> $stable(dac_codes));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
    load_done |=> !load_done);

  assert_done_from_load_R6: assert property (@(posedge clk) disable iff (rst)
    load_ev |=> load_done);
endmodule

bind quad_dac_loader dac_loader_checks #(.SR_W(CH_COUNT*CODE_W)) u_checks (
  .clk(clk), .rst(rst),
  .shift_ev(evt.shift), .load_ev(evt.load),
  .sr_word(sr_word), .ser_dout(ser_dout),
  .dac_codes(dac_codes), .load_done(load_done)
);

// File: tb/test_quad_dac_loader.sv
module test_quad_dac_loader;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b1;
  logic ser_en_n = 1'b1;
  logic ser_din = 1'b0;
  logic ser_dout;
  logic [23:0] dac_codes;
  logic load_done;

  int n_checks = 0;
  int n_errors = 0;
  logic [23:0] m_sr = '0;
  logic [23:0] m_out = '0;

  always #10 clk = ~clk;

  quad_dac_loader i_quad_dac_loader (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_en_n(ser_en_n),
    .ser_din(ser_din), .ser_dout(ser_dout), .dac_codes(dac_codes),
    .load_done(load_done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one serial bit; en_live says whether the enable is low
  task automatic send_bit(input logic b, input logic en_live);
    logic old_dout;
    ser_din = b;
    wait_n(4);
    old_dout = ser_dout;
    ser_clk = 1'b0;
    wait_n(2);
    chk("R10 shift not yet visible", {31'd0, ser_dout}, {31'd0, old_dout});
    wait_n(1);
    if (en_live) m_sr = {m_sr[22:0], b};
    chk(en_live ? "R9 dout is far bit" : "R4 dout unchanged with enable high",
        {31'd0, ser_dout}, {31'd0, m_sr[23]});
    wait_n(1);
    ser_clk = 1'b1;
    wait_n(4);
  endtask

  task automatic send_frame(input int n, input logic [31:0] val);
    ser_en_n = 1'b0;
    wait_n(4);
    for (int i = n - 1; i >= 0; i--) send_bit(val[i], 1'b1);
  endtask

  task automatic finish_frame(input string req);
    ser_en_n = 1'b1;
    wait_n(2);
    chk("R10 load not yet visible", dac_codes, m_out);
    chk("R10 done not yet high", {31'd0, load_done}, 32'd0);
    wait_n(1);
    m_out = m_sr;
    chk(req, dac_codes, m_out);
    chk("R6 done high with update", {31'd0, load_done}, 32'd1);
    wait_n(1);
    chk("R6 done one cycle", {31'd0, load_done}, 32'd0);
    wait_n(4);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    wait_n(3);
    chk("R1 codes in reset", dac_codes, 32'd0);
    chk("R1 dout in reset", {31'd0, ser_dout}, 32'd0);
    chk("R1 done in reset", {31'd0, load_done}, 32'd0);
    rst = 1'b0;
    wait_n(6);
    chk("R1 codes after reset", dac_codes, 32'd0);
    chk("R1 done after reset", {31'd0, load_done}, 32'd0);

    // full frames: every code on every channel position (R2, R3, R5)
    for (int v = 0; v < 64; v++) begin
      logic [5:0] w1, w2, w3, w4;
      w1 = 6'(v);
      w2 = 6'(63 - v);
      w3 = 6'((v * 5) % 64);
      w4 = 6'((v * 11 + 7) % 64);
      send_frame(24, {8'd0, w4, w3, w2, w1});
      finish_frame("R5 parallel load");
      chk("R3 channel 1", {26'd0, dac_codes[5:0]}, {26'd0, w1});
      chk("R3 channel 2", {26'd0, dac_codes[11:6]}, {26'd0, w2});
      chk("R3 channel 3", {26'd0, dac_codes[17:12]}, {26'd0, w3});
      chk("R2 channel 4 msb first", {26'd0, dac_codes[23:18]}, {26'd0, w4});
    end

    // short frames (R7)
    for (int k = 1; k <= 3; k++) begin
      logic [23:0] prev, expv;
      logic [31:0] frame;
      prev  = m_out;
      frame = 32'h00A5C3F0 >> (6 * k);
      frame = frame & ((32'd1 << (6 * k)) - 1);
      expv  = 24'((prev << (6 * k)) | frame);
      send_frame(6 * k, frame);
      finish_frame("R7 short frame");
      chk("R7 leftover bits move up", dac_codes, expv);
    end

    // long frame with don't-care lead bits (R8)
    begin
      logic [23:0] prev;
      prev = m_out;
      send_frame(8, 32'h000000E5);
      finish_frame("R8 long frame");
      chk("R8 channel 1 from last bits", {26'd0, dac_codes[5:0]}, 32'h25);
      chk("R8 upper channels shifted by 8", {8'd0, dac_codes[23:6]},
          {8'd0, prev[15:0], 2'b11});
    end

    // clocks with enable high are ignored (R4)
    begin
      logic [23:0] prev;
      prev = m_out;
      for (int i = 0; i < 6; i++) send_bit(i[0], 1'b0);
      ser_en_n = 1'b0;
      wait_n(4);
      finish_frame("R4 enable-high clocks ignored");
      chk("R4 codes unchanged", dac_codes, prev);
    end

    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
  end
endmodule